// File: doc/BRIEF.md
# DRAM Command Timing Legality Monitor

This block watches the command bus of a graphics DRAM and reports any command that arrives while an earlier timed action is still running. It keeps a record of which banks hold an open row and when the last row activation was accepted. It also tracks a single device-wide window that is opened by an auto refresh, a mode-register write, a power-down exit or a self-refresh exit. All window lengths are module parameters counted in clock cycles, and each must be at least 1.

Each clock, the monitor decodes the command and compares it with the open windows. One clock later it produces a one-cycle violation pulse together with a code that names the rule that was broken. A flagged command counts as not issued, so it leaves all tracking state unchanged. The monitor is passive and sits beside a memory controller or a bus model. It does not model clock-enable power states, data-bus timing or read/write latencies.

Top module: `dram_cmd_guard`

## Requirements
- R1: The synchronous active-high reset `rst` closes every timing window, marks all banks idle and holds `viol` low. The first command after reset is judged as if nothing had been issued before it.
- R2: The verdict for a command sampled at clock edge n shows on `viol` and `viol_code` right after edge n, for exactly one cycle. `viol_code` is 0 whenever `viol` is low.
- R3: The encodings are NOP = 0 and deselect = 1. When `cmd_valid` is low, or the command is NOP or deselect, no violation is raised, and this holds inside every window.
- R4: Activate is encoded 2. An activate to an idle bank that arrives fewer than T_RRD cycles after the last accepted activate gives code 1. At exactly T_RRD cycles it is legal.
- R5: An activate to a bank that already holds an open row gives code 2. This code outranks code 1.
- R6: The encodings are precharge = 3, read = 4, read-autoprecharge = 5, write = 6, write-autoprecharge = 7. Outside the device-wide window these commands never violate, whatever the activation state. Codes 3, 5 and 7 close the addressed bank. Codes 13 to 15 are plain commands that change no state.
- R7: Refresh is encoded 8. Any command other than NOP or deselect arriving 1 to T_RFC-1 cycles after an accepted refresh gives code 3. At T_RFC cycles the window is over.
- R8: Mode-register set (9) and extended mode-register set (10) open a T_MRD-cycle window. During it, any command other than NOP or deselect gives code 4.
- R9: Power-down exit (11) opens a T_XPN-cycle window and self-refresh exit (12) opens a T_XSC-cycle window. Commands other than NOP or deselect inside these windows give code 5 and code 6 respectively.
- R10: While the device-wide window is open, its code (3 to 6) takes priority over the bank codes 1 and 2.
- R11: A flagged command leaves all tracking state unchanged. It opens no window, restarts no activate delay and changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd | input | 4 | Command encoding (see R3 to R9) |
| bank | input | BANK_W | Bank address of the command |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Rule broken (0 = none, 1 to 6 per R4 to R9) |

## Verification
Directed sequences place activates one cycle before and exactly at the row-to-row boundary. This separates an off-by-one delay from a correct one. A repeated activate to an open bank confirms that code 2 outranks code 1. Each device-wide window is probed at its first cycle, at its last cycle and at its closing cycle, with an activate to an open bank placed inside a refresh window to show the window code wins. Flagged activates and flagged refreshes inside windows show whether rejected commands leak into the tracking state. A reset in the middle of a window checks that it clears. A seeded random stream mixes every encoding, including unused codes and idle strobes, against a bench model of the rules.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_DESEL = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_PRE   = 4'd3,
        CMD_RD    = 4'd4,
        CMD_RDA   = 4'd5,
        CMD_WR    = 4'd6,
        CMD_WRA   = 4'd7,
        CMD_REF   = 4'd8,
        CMD_MRS   = 4'd9,
        CMD_EMRS  = 4'd10,
        CMD_PDX   = 4'd11,
        CMD_SRX   = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        VC_NONE = 3'd0,
        VC_RRD  = 3'd1,
        VC_OPEN = 3'd2,
        VC_REF  = 3'd3,
        VC_MRS  = 3'd4,
        VC_PDX  = 3'd5,
        VC_SRX  = 3'd6
    } vcode_e;

    // Decoded view of one bus cycle
    typedef struct packed {
        logic   real_cmd;   // something other than idle / NOP / deselect
        logic   is_act;
        logic   closes;     // closes the addressed bank
        logic   opens;      // opens the device-wide window
        vcode_e wcode;      // code reported while that window is open
    } cmd_dec_t;

    typedef struct packed {
        logic   flag;
        vcode_e code;
    } verdict_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_dec_t decode(input logic valid, input logic [3:0] raw);
        cmd_dec_t d;
        d = '{real_cmd: valid, is_act: 1'b0, closes: 1'b0, opens: 1'b0, wcode: VC_NONE};
        case (cmd_e'(raw))
            CMD_NOP, CMD_DESEL: d.real_cmd = 1'b0;
            CMD_ACT:            d.is_act   = valid;
            CMD_PRE, CMD_RDA, CMD_WRA: d.closes = valid;
            CMD_REF: begin d.opens = valid; d.wcode = VC_REF; end
            CMD_MRS, CMD_EMRS: begin d.opens = valid; d.wcode = VC_MRS; end
            CMD_PDX: begin d.opens = valid; d.wcode = VC_PDX; end
            CMD_SRX: begin d.opens = valid; d.wcode = VC_SRX; end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dcg_countdown.sv
module dcg_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/dcg_global_window.sv
module dcg_global_window
    import dcg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         open,
    input  vcode_e       open_code,
    input  logic [W-1:0] open_len,
    output logic         busy,
    output vcode_e       code
);
    dcg_countdown #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (open),
        .load_val (open_len),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)       code <= VC_NONE;
        else if (open) code <= open_code;
    end
endmodule

// File: rtl/dcg_bank_track.sv
module dcg_bank_track #(
    parameter int BW = 3,
    localparam int N = 1 << BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set,
    input  logic          clr,
    input  logic [BW-1:0] bank,
    output logic [N-1:0]  open_mask
);
    for (genvar b = 0; b < N; b++) begin : g_bank
        logic hit;
        assign hit = (bank == BW'(b));
        always_ff @(posedge clk) begin
            if (rst)              open_mask[b] <= 1'b0;
            else if (set && hit)  open_mask[b] <= 1'b1;
            else if (clr && hit)  open_mask[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard
    import dcg_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int T_RRD  = 2,
    parameter int T_RFC  = 44,
    parameter int T_MRD  = 5,
    parameter int T_XPN  = 6,
    parameter int T_XSC  = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    output logic              viol,
    output logic [2:0]        viol_code
);
    localparam int N_BANKS = 1 << BANK_W;
    localparam int T_MAX   = imax(imax(imax(T_RFC, T_MRD), imax(T_XPN, T_XSC)), T_RRD);
    localparam int CNT_W   = ($clog2(T_MAX) < 1) ? 1 : $clog2(T_MAX);
    localparam logic [CNT_W-1:0] LEN_RRD = CNT_W'(T_RRD - 1);
    localparam logic [CNT_W-1:0] LEN_RFC = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LEN_MRD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] LEN_XPN = CNT_W'(T_XPN - 1);
    localparam logic [CNT_W-1:0] LEN_XSC = CNT_W'(T_XSC - 1);

    cmd_dec_t           dec;
    verdict_t           verdict;
    verdict_t           verdict_q;
    logic               accept;
    logic               glob_busy;
    vcode_e             glob_code;
    logic               rrd_busy;
    logic [N_BANKS-1:0] bank_open;
    logic [CNT_W-1:0]   win_len;

    assign dec = decode(cmd_valid, cmd);

    // Priority: device-wide window, then open bank, then row-to-row delay
    always_comb begin
        verdict = '{flag: 1'b0, code: VC_NONE};
        if (dec.real_cmd) begin
            if (glob_busy)
                verdict = '{flag: 1'b1, code: glob_code};
            else if (dec.is_act && bank_open[bank])
                verdict = '{flag: 1'b1, code: VC_OPEN};
            else if (dec.is_act && rrd_busy)
                verdict = '{flag: 1'b1, code: VC_RRD};
        end
    end

    // Rejected commands never reach the tracking state (R11)
    assign accept = dec.real_cmd && !verdict.flag;

    always_comb begin
        case (dec.wcode)
            VC_REF:  win_len = LEN_RFC;
            VC_MRS:  win_len = LEN_MRD;
            VC_PDX:  win_len = LEN_XPN;
            VC_SRX:  win_len = LEN_XSC;
            default: win_len = '0;
        endcase
    end

    dcg_countdown #(.W(CNT_W)) u_rrd (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && dec.is_act),
        .load_val (LEN_RRD),
        .busy     (rrd_busy)
    );

    dcg_global_window #(.W(CNT_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .open      (accept && dec.opens),
        .open_code (dec.wcode),
        .open_len  (win_len),
        .busy      (glob_busy),
        .code      (glob_code)
    );

    dcg_bank_track #(.BW(BANK_W)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .set       (accept && dec.is_act),
        .clr       (accept && dec.closes),
        .bank      (bank),
        .open_mask (bank_open)
    );

    always_ff @(posedge clk) begin
        if (rst) verdict_q <= '{flag: 1'b0, code: VC_NONE};
        else     verdict_q <= verdict;
    end

    assign viol      = verdict_q.flag;
    assign viol_code = verdict_q.code;
endmodule

// File: rtl/dcg_checker.sv
module dcg_checker
    import dcg_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int N_BANKS = 1 << BANK_W
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic [3:0]         cmd,
    input logic [BANK_W-1:0]  bank,
    input logic               viol,
    input logic [2:0]         viol_code,
    input logic [N_BANKS-1:0] bank_open,
    input logic               glob_busy,
    input logic               rrd_busy
);
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !viol);

    p_code_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !viol |-> viol_code == 3'd0);

    p_code_set_r2: assert property (@(posedge clk) disable iff (rst)
        viol |-> viol_code != 3'd0);

    p_idle_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd == CMD_NOP || cmd == CMD_DESEL) |=> !viol);

    p_rrd_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == CMD_ACT && !glob_busy && !bank_open[bank] && rrd_busy)
        |=> (viol && viol_code == VC_RRD));

    p_open_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == CMD_ACT && !glob_busy && bank_open[bank])
        |=> (viol && viol_code == VC_OPEN));

    p_rw_pre_legal_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !glob_busy && cmd inside {CMD_PRE, CMD_RD, CMD_RDA, CMD_WR, CMD_WRA})
        |=> !viol);

    p_window_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && glob_busy && cmd != CMD_NOP && cmd != CMD_DESEL)
        |=> (viol && viol_code >= VC_REF));
endmodule

bind dram_cmd_guard dcg_checker #(.BANK_W(BANK_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .bank      (bank),
    .viol      (viol),
    .viol_code (viol_code),
    .bank_open (bank_open),
    .glob_busy (glob_busy),
    .rrd_busy  (rrd_busy)
);

// File: tb/dram_cmd_guard_tb_top.sv
module dram_cmd_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BW    = 2;
    localparam int NB    = 1 << BW;
    localparam int T_RRD = 3;
    localparam int T_RFC = 12;
    localparam int T_MRD = 4;
    localparam int T_XPN = 2;
    localparam int T_XSC = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd = 4'd0;
    logic [BW-1:0] bank = '0;
    logic          viol;
    logic [2:0]    viol_code;

    int total = 0;
    int bad   = 0;

    // reference model state
    bit      act_m [NB];
    longint  cyc = 0;
    longint  rrd_until = 0;
    longint  win_until = 0;
    int      win_code_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cmd_guard #(
        .BANK_W(BW), .T_RRD(T_RRD), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .T_XPN(T_XPN), .T_XSC(T_XSC)
    ) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .bank(bank), .viol(viol), .viol_code(viol_code)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_code(input bit v, input int c, input int b);
        if (!v || c == 0 || c == 1) return 0;
        if (cyc < win_until) return win_code_m;
        if (c == 2) begin
            if (act_m[b]) return 2;
            if (cyc < rrd_until) return 1;
        end
        return 0;
    endfunction

    function automatic void model_apply(input bit v, input int c, input int b, input int ec);
        if (!v || c <= 1 || ec != 0) return;
        case (c)
            2: begin act_m[b] = 1'b1; rrd_until = cyc + T_RRD; end
            3, 5, 7: act_m[b] = 1'b0;
            8:  begin win_until = cyc + T_RFC; win_code_m = 3; end
            9, 10: begin win_until = cyc + T_MRD; win_code_m = 4; end
            11: begin win_until = cyc + T_XPN; win_code_m = 5; end
            12: begin win_until = cyc + T_XSC; win_code_m = 6; end
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input bit v, input int c, input int ec);
        case (ec)
            1: return "R4";
            2: return "R5";
            3: return "R7";
            4: return "R8";
            5, 6: return "R9";
            default: ;
        endcase
        if (!v || c <= 1) return "R3";
        if (c == 2) return "R4";
        if (c == 8) return "R7";
        if (c == 9 || c == 10) return "R8";
        if (c == 11 || c == 12) return "R9";
        return "R6";
    endfunction

    task automatic issue(input bit v, input int c, input int b, input string tag);
        int ec;
        string t;
        @(negedge clk);
        cmd_valid = v;
        cmd = c[3:0];
        bank = b[BW-1:0];
        ec = model_code(v, c, b);
        t = (tag == "") ? tag_of(v, c, ec) : tag;
        @(posedge clk);
        #1;
        check({viol, viol_code} == {ec != 0, ec[2:0]}, t, "verdict {viol,code}",
              int'({viol, viol_code}), int'({ec != 0, ec[2:0]}));
        model_apply(v, c, b, ec);
        cyc++;
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(1'b1, 0, 0, "");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NB; i++) act_m[i] = 1'b0;
        rrd_until = 0;
        win_until = 0;
        win_code_m = 0;
        check(viol == 1'b0, "R1", "viol after reset", int'(viol), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5113));
        do_reset();

        // R4 / R11 / R2: row-to-row delay boundary and rejected activate
        issue(1'b1, 2, 0, "R4");
        issue(1'b1, 2, 1, "R4");   // one cycle later: code 1
        issue(1'b1, 0, 0, "R2");   // pulse drops
        issue(1'b1, 2, 1, "R11");  // exactly T_RRD after the accepted one
        issue(1'b1, 2, 0, "R5");   // open bank outranks delay
        // R6: reads, writes and precharges during activation
        issue(1'b1, 4, 0, "R6");
        issue(1'b1, 7, 1, "R6");
        issue(1'b1, 3, 2, "R6");
        issue(1'b1, 5, 0, "R6");
        issue(1'b1, 14, 3, "R6");
        issue(1'b1, 2, 1, "R6");   // bank 1 closed by write-autoprecharge

        // R7 / R10: refresh window edges
        issue(1'b1, 8, 0, "R7");
        issue(1'b1, 4, 0, "R7");
        issue(1'b0, 2, 2, "R3");   // idle strobe inside window
        issue(1'b1, 1, 0, "R3");
        nops(T_RFC - 5);
        issue(1'b1, 2, 1, "R10");  // bank 1 open, still refresh code
        issue(1'b1, 4, 1, "R7");   // window over

        // R8 / R11: mode register window with rejected refresh
        issue(1'b1, 9, 0, "R8");
        issue(1'b1, 8, 0, "R8");
        nops(T_MRD - 2);
        issue(1'b1, 2, 2, "R11");  // legal only if refresh was not taken
        issue(1'b1, 10, 0, "R8");
        issue(1'b1, 6, 2, "R8");
        nops(T_MRD - 2);

        // R9: exit windows
        issue(1'b1, 11, 0, "R9");
        issue(1'b1, 3, 1, "R9");
        issue(1'b1, 3, 1, "R9");
        issue(1'b1, 12, 0, "R9");
        nops(T_XSC - 2);
        issue(1'b1, 4, 0, "R9");
        issue(1'b1, 4, 0, "R9");

        // R1: reset in the middle of a refresh window
        issue(1'b1, 8, 0, "R7");
        do_reset();
        issue(1'b1, 2, 2, "R1");   // bank 2 had been open
        issue(1'b1, 2, 3, "R4");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            int r;
            int c;
            int b;
            r = int'($urandom % 100);
            c = int'($urandom % 16);
            b = int'($urandom % NB);
            if (r < 45)      issue(1'b1, 0, b, "");
            else if (r < 52) issue(1'b0, c, b, "");
            else if (r < 70) issue(1'b1, 2, b, "");
            else             issue(1'b1, c, b, "");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule